// File: doc/BRIEF.md
# Pipeline Hazard Stall/Bubble Controller

This block is the control unit of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). Each cycle it looks at the instructions that sit in the decode, execute and memory pipeline registers. It then decides, for each of the five pipeline registers, whether that register loads normally, holds its contents (stall), or loads a no-operation (bubble) at the next clock edge. The pipeline registers apply these decisions at that edge.

The controller handles three hazard classes. The first is a load followed at once by a consumer of the loaded register. This costs one stall cycle, after which the value is forwarded from the memory stage. The second is a conditional jump that was predicted taken but resolves not taken in execute; the two wrongly fetched instructions are squashed. The third is a return, which needs fetch frozen until the return address is loaded. The controller is purely combinational, and it also settles the cases where two of these hazards are present in the same cycle.

Top module: `hzd_pipe_ctl`

## Requirements
- R1: When the execute opcode is load (4'h5) or pop (4'hB) and its load destination ID equals decode source A or source B, the outputs are stall_f=1, stall_d=1 and bubble_e=1, with bubble_d=0.
- R2: A load destination ID of all ones (4'hF, "no register") never produces the load/use action, even when a decode source is also all ones.
- R3: Execute opcodes other than load and pop, including call (4'h8) and jump (4'h7), never produce the load/use action, even when the destination ID matches a source.
- R4: When the execute opcode is jump (4'h7) and e_cond_ok=0, the outputs are bubble_d=1 and bubble_e=1, with stall_d=0 and stall_f=0 unless a return is also present.
- R5: A jump with e_cond_ok=1, or e_cond_ok=0 with a non-jump opcode, causes no misprediction action.
- R6: While the return opcode (4'h9) is in decode, execute or memory, stall_f=1 and bubble_d=1. Once the return has left memory, both drop to 0.
- R7: When a load/use hazard and a return are present together, decode is stalled and not bubbled: stall_f=1, stall_d=1, bubble_d=0, bubble_e=1.
- R8: When a misprediction and a return in decode are present together, stall_f=1, bubble_d=1 and bubble_e=1, with stall_d=0.
- R9: stall_e, stall_m, stall_w, bubble_f, bubble_m and bubble_w are always 0, and no stage ever has its stall and bubble controls set at once.
- R10: With none of the three hazards present, all ten control outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| d_op | input | 4 | Opcode held in the decode register |
| e_op | input | 4 | Opcode held in the execute register |
| m_op | input | 4 | Opcode held in the memory register |
| e_dst_ld | input | RID_W | Load destination register ID of the execute instruction |
| d_src_a | input | RID_W | First source register ID of the decode instruction |
| d_src_b | input | RID_W | Second source register ID of the decode instruction |
| e_cond_ok | input | 1 | Branch condition evaluated in execute (1 = taken) |
| stall_f | output | 1 | Hold the fetch register |
| bubble_f | output | 1 | Load a no-op into the fetch register |
| stall_d | output | 1 | Hold the decode register |
| bubble_d | output | 1 | Load a no-op into the decode register |
| stall_e | output | 1 | Hold the execute register |
| bubble_e | output | 1 | Load a no-op into the execute register |
| stall_m | output | 1 | Hold the memory register |
| bubble_m | output | 1 | Load a no-op into the memory register |
| stall_w | output | 1 | Hold the write-back register |
| bubble_w | output | 1 | Load a no-op into the write-back register |

## Verification
A return can share a cycle with either of the other two hazards, and these pairs are where the control decisions could clash. The bench builds both cases. In one, a pop in execute targets a register that a return in decode reads, and the bench expects decode to be held rather than squashed. In the other, a jump that resolves not taken sits in execute behind a return fetched at its target, and the bench expects decode and execute to be squashed with fetch frozen. Each hazard sequence is also replayed cycle by cycle, including the one-cycle load stall, the two-slot branch squash and the three-cycle return drain, and the bench checks every stage's controls against a queue of expected values.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  localparam int OP_W  = 4;
  localparam int N_STG = 5;

  typedef logic [OP_W-1:0] op_t;

  localparam op_t OP_LOAD = 4'h5;
  localparam op_t OP_JMP  = 4'h7;
  localparam op_t OP_CALL = 4'h8;
  localparam op_t OP_RET  = 4'h9;
  localparam op_t OP_POP  = 4'hB;

  // stage slots inside the control vector
  localparam int STG_F = 0;
  localparam int STG_D = 1;
  localparam int STG_E = 2;
  localparam int STG_M = 3;
  localparam int STG_W = 4;

  typedef struct packed {
    logic stall;
    logic bubble;
  } stg_ctl_t;

  function automatic logic op_reads_mem(op_t op);
    return (op == OP_LOAD) || (op == OP_POP);
  endfunction

endpackage

// File: rtl/hzd_loaduse_det.sv
module hzd_loaduse_det
  import hzd_pkg::*;
#(
  parameter int RID_W = 4,
  parameter int N_SRC = 2
) (
  input  op_t                         e_op,
  input  logic [RID_W-1:0]            e_dst,
  input  logic [N_SRC-1:0][RID_W-1:0] srcs,
  output logic                        hit
);

  localparam logic [RID_W-1:0] NOREG = '1;

  logic [N_SRC-1:0] src_match;

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign src_match[i] = (srcs[i] == e_dst);
    end
  endgenerate

  assign hit = op_reads_mem(e_op) && (e_dst != NOREG) && (|src_match);

endmodule

// File: rtl/hzd_mispred_det.sv
module hzd_mispred_det
  import hzd_pkg::*;
(
  input  op_t  e_op,
  input  logic e_cond_ok,
  output logic hit
);

  // predict-taken: only a not-taken outcome needs repair
  assign hit = (e_op == OP_JMP) && !e_cond_ok;

endmodule

// File: rtl/hzd_ret_det.sv
module hzd_ret_det
  import hzd_pkg::*;
#(
  parameter int N_WATCH = 3
) (
  input  op_t [N_WATCH-1:0] ops,
  output logic              busy
);

  logic [N_WATCH-1:0] seen;

  generate
    for (genvar i = 0; i < N_WATCH; i++) begin : g_watch
      assign seen[i] = (ops[i] == OP_RET);
    end
  endgenerate

  assign busy = |seen;

endmodule

// File: rtl/hzd_ctl_merge.sv
module hzd_ctl_merge
  import hzd_pkg::*;
(
  input  logic                 luh,
  input  logic                 mis,
  input  logic                 ret,
  output stg_ctl_t [N_STG-1:0] ctl
);

  always_comb begin
    ctl = '0;
    ctl[STG_F].stall  = luh | ret;
    ctl[STG_D].stall  = luh;
    // holding decode wins over squashing it
    ctl[STG_D].bubble = mis | (ret & ~luh);
    ctl[STG_E].bubble = mis | luh;
  end

endmodule

// File: rtl/hzd_pipe_ctl.sv
module hzd_pipe_ctl
  import hzd_pkg::*;
#(
  parameter int RID_W = 4
) (
  input  logic [3:0]       d_op,
  input  logic [3:0]       e_op,
  input  logic [3:0]       m_op,
  input  logic [RID_W-1:0] e_dst_ld,
  input  logic [RID_W-1:0] d_src_a,
  input  logic [RID_W-1:0] d_src_b,
  input  logic             e_cond_ok,
  output logic             stall_f,
  output logic             bubble_f,
  output logic             stall_d,
  output logic             bubble_d,
  output logic             stall_e,
  output logic             bubble_e,
  output logic             stall_m,
  output logic             bubble_m,
  output logic             stall_w,
  output logic             bubble_w
);

  localparam int N_WATCH = 3;

  logic                        luh_hit;
  logic                        mis_hit;
  logic                        ret_busy;
  logic [1:0][RID_W-1:0]       src_vec;
  op_t  [N_WATCH-1:0]          watch_ops;
  stg_ctl_t [N_STG-1:0]        ctl;

  assign src_vec   = {d_src_b, d_src_a};
  assign watch_ops = {m_op, e_op, d_op};

  hzd_loaduse_det #(.RID_W(RID_W), .N_SRC(2)) u_luh (
    .e_op  (e_op),
    .e_dst (e_dst_ld),
    .srcs  (src_vec),
    .hit   (luh_hit)
  );

  hzd_mispred_det u_mis (
    .e_op      (e_op),
    .e_cond_ok (e_cond_ok),
    .hit       (mis_hit)
  );

  hzd_ret_det #(.N_WATCH(N_WATCH)) u_ret (
    .ops  (watch_ops),
    .busy (ret_busy)
  );

  hzd_ctl_merge u_merge (
    .luh (luh_hit),
    .mis (mis_hit),
    .ret (ret_busy),
    .ctl (ctl)
  );

  assign stall_f  = ctl[STG_F].stall;
  assign bubble_f = ctl[STG_F].bubble;
  assign stall_d  = ctl[STG_D].stall;
  assign bubble_d = ctl[STG_D].bubble;
  assign stall_e  = ctl[STG_E].stall;
  assign bubble_e = ctl[STG_E].bubble;
  assign stall_m  = ctl[STG_M].stall;
  assign bubble_m = ctl[STG_M].bubble;
  assign stall_w  = ctl[STG_W].stall;
  assign bubble_w = ctl[STG_W].bubble;

endmodule

// File: rtl/hzd_pipe_ctl_chk.sv
module hzd_pipe_ctl_chk
  import hzd_pkg::*;
#(
  parameter int RID_W = 4
) (
  input logic [3:0]       d_op,
  input logic [3:0]       e_op,
  input logic [3:0]       m_op,
  input logic [RID_W-1:0] e_dst_ld,
  input logic [RID_W-1:0] d_src_a,
  input logic [RID_W-1:0] d_src_b,
  input logic             e_cond_ok,
  input logic             stall_f,
  input logic             bubble_f,
  input logic             stall_d,
  input logic             bubble_d,
  input logic             stall_e,
  input logic             bubble_e,
  input logic             stall_m,
  input logic             bubble_m,
  input logic             stall_w,
  input logic             bubble_w
);

  localparam logic [RID_W-1:0] NOREG = '1;

  logic ld_in_e, src_hit, ret_any, bad_jmp;

  always_comb begin
    ld_in_e = (e_op == OP_LOAD) || (e_op == OP_POP);
    src_hit = (e_dst_ld != NOREG) && ((e_dst_ld == d_src_a) || (e_dst_ld == d_src_b));
    ret_any = (d_op == OP_RET) || (e_op == OP_RET) || (m_op == OP_RET);
    bad_jmp = (e_op == OP_JMP) && !e_cond_ok;

    p_luh_action_r1: assert (!(ld_in_e && src_hit) || (stall_f && stall_d && bubble_e && !bubble_d))
      else $error("load/use action missing");
    p_noreg_quiet_r2: assert (!(e_dst_ld == NOREG) || !stall_d)
      else $error("no-register ID stalled decode");
    p_call_quiet_r3: assert (!(e_op == OP_CALL) || !stall_d)
      else $error("call in execute stalled decode");
    p_mis_action_r4: assert (!bad_jmp || (bubble_d && bubble_e && !stall_d))
      else $error("mispredict squash missing");
    p_ret_hold_r6: assert (!ret_any || stall_f)
      else $error("fetch not held during return");
    p_ret_squash_r6: assert (!(ret_any && !stall_d) || bubble_d)
      else $error("decode not squashed during return");
    p_prec_r7: assert (!stall_d || !bubble_d)
      else $error("decode stalled and squashed at once");
    p_idle_stages_r9: assert (!(stall_e || stall_m || stall_w || bubble_f || bubble_m || bubble_w))
      else $error("control raised on an idle stage");
    p_quiet_r10: assert (ret_any || bad_jmp || (ld_in_e && src_hit)
                         || !(stall_f || stall_d || bubble_d || bubble_e))
      else $error("control raised without hazard");
  end

endmodule

bind hzd_pipe_ctl hzd_pipe_ctl_chk #(.RID_W(RID_W)) u_chk (
  .d_op(d_op), .e_op(e_op), .m_op(m_op), .e_dst_ld(e_dst_ld),
  .d_src_a(d_src_a), .d_src_b(d_src_b), .e_cond_ok(e_cond_ok),
  .stall_f(stall_f), .bubble_f(bubble_f), .stall_d(stall_d), .bubble_d(bubble_d),
  .stall_e(stall_e), .bubble_e(bubble_e), .stall_m(stall_m), .bubble_m(bubble_m),
  .stall_w(stall_w), .bubble_w(bubble_w)
);

// File: tb/sim_hzd_pipe_ctl.sv
`timescale 1ns/1ps
module sim_hzd_pipe_ctl;

  localparam logic [3:0] NOP = 4'h0, ALU = 4'h6, LD = 4'h5, JMP = 4'h7;
  localparam logic [3:0] CALL = 4'h8, RET = 4'h9, POP = 4'hB, NR = 4'hF;

  // vector order: {sf,bf, sd,bd, se,be, sm,bm, sw,bw}
  localparam logic [9:0] X_NONE    = 10'b00_00_00_00_00;
  localparam logic [9:0] X_LUH     = 10'b10_10_01_00_00;
  localparam logic [9:0] X_MIS     = 10'b00_01_01_00_00;
  localparam logic [9:0] X_RET     = 10'b10_01_00_00_00;
  localparam logic [9:0] X_MIS_RET = 10'b10_01_01_00_00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] d_op, e_op, m_op, e_dst_ld, d_src_a, d_src_b;
  logic       e_cond_ok;
  logic stall_f, bubble_f, stall_d, bubble_d, stall_e, bubble_e;
  logic stall_m, bubble_m, stall_w, bubble_w;

  hzd_pipe_ctl u0 (
    .d_op(d_op), .e_op(e_op), .m_op(m_op), .e_dst_ld(e_dst_ld),
    .d_src_a(d_src_a), .d_src_b(d_src_b), .e_cond_ok(e_cond_ok),
    .stall_f(stall_f), .bubble_f(bubble_f), .stall_d(stall_d), .bubble_d(bubble_d),
    .stall_e(stall_e), .bubble_e(bubble_e), .stall_m(stall_m), .bubble_m(bubble_m),
    .stall_w(stall_w), .bubble_w(bubble_w)
  );

  typedef struct {
    logic [9:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  initial begin
    d_op = NOP; e_op = NOP; m_op = NOP;
    e_dst_ld = NR; d_src_a = NR; d_src_b = NR; e_cond_ok = 1'b1;
  end

  task automatic step(input logic [3:0] d, input logic [3:0] e, input logic [3:0] m,
                      input logic [3:0] dst, input logic [3:0] sa, input logic [3:0] sb,
                      input logic cond, input logic [9:0] exp, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    d_op = d; e_op = e; m_op = m;
    e_dst_ld = dst; d_src_a = sa; d_src_b = sb; e_cond_ok = cond;
    it.exp = exp;
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: samples half a cycle after inputs change
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && q.size() > 0) begin
        item_t it;
        logic [9:0] got;
        it  = q.pop_front();
        got = {stall_f, bubble_f, stall_d, bubble_d, stall_e, bubble_e,
               stall_m, bubble_m, stall_w, bubble_w};
        n_run++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got %b expected %b", it.tag, got, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset / quiet state (R10, R9)
    step(NOP, NOP, NOP, NR, NR, NR, 1'b1, X_NONE, "R10 quiet after reset");
    // load/use replay: hazard then one-cycle release (R1)
    step(ALU, LD,  NOP, 4'd2, 4'd2, 4'd0, 1'b1, X_LUH,  "R1 load hits src A");
    step(ALU, NOP, LD,  NR,   4'd2, 4'd0, 1'b1, X_NONE, "R1 release after bubble");
    step(ALU, POP, NOP, 4'd3, 4'd1, 4'd3, 1'b1, X_LUH,  "R1 pop hits src B");
    step(ALU, LD,  NOP, 4'd4, 4'd1, 4'd2, 1'b1, X_NONE, "R1 no source match");
    // no-register ID (R2)
    step(ALU, LD,  NOP, NR,   NR,   NR,   1'b1, X_NONE, "R2 noreg never matches");
    // other opcodes with matching IDs (R3, R5)
    step(ALU, CALL, NOP, 4'd5, 4'd5, 4'd5, 1'b1, X_NONE, "R3 call ignored");
    step(ALU, ALU,  NOP, 4'd6, 4'd6, 4'd0, 1'b0, X_NONE, "R3 R5 alu ignored");
    step(ALU, JMP,  NOP, 4'd1, 4'd1, 4'd1, 1'b1, X_NONE, "R3 R5 taken jump quiet");
    // mispredict replay: squash then clean (R4)
    step(ALU, JMP, NOP, NR, 4'd0, 4'd1, 1'b0, X_MIS,  "R4 not-taken jump");
    step(NOP, NOP, JMP, NR, NR,   NR,   1'b1, X_NONE, "R4 after squash");
    // return drain replay (R6)
    step(RET, ALU, NOP, NR, 4'd4, NR, 1'b1, X_RET,  "R6 ret in decode");
    step(NOP, RET, ALU, NR, NR,   NR, 1'b1, X_RET,  "R6 ret in execute");
    step(NOP, NOP, RET, NR, NR,   NR, 1'b1, X_RET,  "R6 ret in memory");
    step(NOP, NOP, NOP, NR, NR,   NR, 1'b1, X_NONE, "R6 ret in writeback releases");
    // load/use with return in decode (R7)
    step(RET, POP, NOP, 4'd4, 4'd4, 4'd4, 1'b1, X_LUH, "R7 luh over ret");
    step(RET, NOP, POP, NR,   4'd4, 4'd4, 1'b1, X_RET, "R7 ret after luh");
    // mispredict with return at target (R8)
    step(RET, JMP, ALU, NR, 4'd4, 4'd4, 1'b0, X_MIS_RET, "R8 mis with ret");
    step(NOP, NOP, JMP, NR, NR,   NR,   1'b1, X_NONE,    "R8 after squash");
    repeat (3) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule